// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block moves a clock generator into and out of its low-power state. It responds to an active-low power-down request that may arrive at any time with no relation to the clock. It builds four output clock groups from a single fast system clock: a CPU group, a stoppable PCI group, a free-running PCI group and a reference group. The CPU and PCI groups can also be parked on their own by separate stop requests.

When power-down is requested, the request is first synchronized. Every group then finishes the period it is in and holds its output low. The oscillator and VCO enables are dropped only after that. When the request is released, the block turns the oscillator and VCO back on and waits a programmable stabilization interval. Only then does it raise the ready flag and let the clocks start again. A request that returns during that wait sends the block straight back to the off state, and no clock is released.

Every output pulse is either a full high phase or absent. No short or stretched pulse appears at stop, power-down or wake-up.

Top module: `pd_seq`

## Requirements
- R1: After reset release the block is in the stabilization wait: osc_en_o and vco_en_o are 1, ready_o is 0 and all four clock outputs are low.
- R2: After pd_ni falls, cpu_clk_o is held low within three CPU clock periods (3 * 2 * CPU_HALF cycles of clk_i) and stays low.
- R3: osc_en_o and vco_en_o fall together, and only after all four clock outputs are parked low. While they are 0, every clock output is low. The flag triple {osc_en_o, vco_en_o, ready_o} moves 110 -> 000 on entry and 000 -> 110 -> 111 on exit.
- R4: ready_o rises between STAB_CYCLES and STAB_CYCLES+5 clk_i cycles after pd_ni rises (or after reset release). No clock output toggles before ready_o rises.
- R5: Every high pulse on a group output lasts exactly HALF cycles of clk_i for that group. Every low gap lasts at least HALF cycles. This holds through stops, power-down entry and wake-up.
- R6: While running, a group with half period HALF has one rising edge every 2*HALF cycles of clk_i.
- R7: cpu_stop_ni low parks cpu_clk_o low at the end of its current period, while the other groups keep running. Releasing it restarts the CPU group.
- R8: pci_stop_ni low parks pci_clk_o low, while pcif_clk_o and cpu_clk_o keep running.
- R9: While powered down or waiting for stabilization, cpu_stop_ni and pci_stop_ni have no effect: no clock toggles and osc_en_o is unchanged.
- R10: If pd_ni falls again during the stabilization wait, the block returns to the off state (flags 110 -> 000) and ready_o never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, source of all group clocks and timing |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_ni | input | 1 | Asynchronous CPU group stop, active low |
| pci_stop_ni | input | 1 | Asynchronous stoppable PCI group stop, active low |
| cpu_clk_o | output | 1 | CPU group clock, half period CPU_HALF |
| pci_clk_o | output | 1 | Stoppable PCI group clock, half period PCI_HALF |
| pcif_clk_o | output | 1 | Free-running PCI group clock, half period PCI_HALF |
| ref_clk_o | output | 1 | Reference group clock, half period REF_HALF |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |
| ready_o | output | 1 | High while clocks are released |

## Verification
The assertions take as given that the three request inputs pass only through the block's own synchronizers, and that a power-down request is held long enough for the synchronized level to be seen. The pulse-width and ordering properties rely on every group being timed from clk_i alone. The stimulus changes each request a few nanoseconds after a rising edge and holds it for many cycles. It toggles the stop inputs only while the block is either running or clearly parked, and restores them before the stabilization wait ends. The power-down input is reasserted only well inside that wait.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PARK = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAKE = 2'd3
  } pd_state_e;

  localparam int unsigned NUM_GRP = 4;
  localparam int unsigned GRP_CPU  = 0;
  localparam int unsigned GRP_PCI  = 1;
  localparam int unsigned GRP_PCIF = 2;
  localparam int unsigned GRP_REF  = 3;
endpackage

// File: rtl/pd_sync_bank.sv
module pd_sync_bank #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pd_stab_timer.sv
module pd_stab_timer #(
  parameter int unsigned STAB_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4
endmodule

// File: rtl/pd_clk_group.sv
module pd_clk_group #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o,
  output logic parked_o
);
  localparam int unsigned PER = 2 * HALF;
  localparam int unsigned CW  = (PER > 2) ? $clog2(PER) : 1;
  localparam logic [CW-1:0] LAST  = CW'(PER - 1);
  localparam logic [CW-1:0] HI_LIM = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_d;
  logic act_q, act_d, clk_q;

  // gating decision taken only at the period boundary
  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    act_d = (cnt_q == LAST) ? en_i : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LAST;
      act_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      clk_q <= act_d && (cnt_d < HI_LIM);
    end
  end

  assign clk_o    = clk_q;
  assign parked_o = !act_q;

  // pulse-length trackers for the checks below
  localparam int unsigned LW = $clog2(HALF + 2);
  logic [LW-1:0] hi_len_q, lo_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len_q <= '0;
      lo_len_q <= '0;
    end else begin
      hi_len_q <= clk_q ? ((hi_len_q == LW'(HALF + 1)) ? hi_len_q : hi_len_q + 1'b1) : '0;
      lo_len_q <= clk_q ? '0 : ((lo_len_q == LW'(HALF)) ? lo_len_q : lo_len_q + 1'b1);
    end
  end

  AST_HIGH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_q) |-> hi_len_q == LW'(HALF)); // R5
  AST_LOW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |-> lo_len_q == LW'(HALF)); // R5
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_s_i,
  input  logic      all_parked_i,
  input  logic      stab_done_i,
  output pd_state_e state_o
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (!pd_s_i) state_d = ST_PARK;
      ST_PARK: if (all_parked_i) state_d = ST_OFF;
      ST_OFF:  if (pd_s_i) state_d = ST_WAKE;
      ST_WAKE: begin
        if (!pd_s_i)          state_d = ST_OFF;
        else if (stab_done_i) state_d = ST_RUN;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAKE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_ABORT_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE && !pd_s_i) |=> state_q == ST_OFF); // R10
  AST_OFF_FROM_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && $past(state_q) != ST_OFF) |-> $past(state_q) inside {ST_PARK, ST_WAKE}); // R3
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_seq_pkg::*;
#(
  parameter int unsigned CPU_HALF    = 2,
  parameter int unsigned PCI_HALF    = 4,
  parameter int unsigned REF_HALF    = 7,
  parameter int unsigned STAB_CYCLES = 100000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic cpu_stop_ni,
  input  logic pci_stop_ni,
  output logic cpu_clk_o,
  output logic pci_clk_o,
  output logic pcif_clk_o,
  output logic ref_clk_o,
  output logic osc_en_o,
  output logic vco_en_o,
  output logic ready_o
);
  function automatic int unsigned grp_half(int unsigned g);
    case (g)
      GRP_CPU:  return CPU_HALF;
      GRP_PCI:  return PCI_HALF;
      GRP_PCIF: return PCI_HALF;
      default:  return REF_HALF;
    endcase
  endfunction

  logic [2:0] req_s;
  logic pd_s, cpu_go_s, pci_go_s;
  pd_state_e state;
  logic run, stab_done, all_parked;
  logic [NUM_GRP-1:0] grp_en, grp_clk, grp_parked;

  pd_sync_bank #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pd_ni, cpu_stop_ni, pci_stop_ni}),
    .q_o   (req_s)
  );
  assign {pd_s, cpu_go_s, pci_go_s} = req_s;

  pd_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state == ST_WAKE),
    .done_o(stab_done)
  );

  pd_seq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pd_s_i      (pd_s),
    .all_parked_i(all_parked),
    .stab_done_i (stab_done),
    .state_o     (state)
  );

  assign run = (state == ST_RUN);
  // stop requests only matter while running
  assign grp_en[GRP_CPU]  = run && cpu_go_s;
  assign grp_en[GRP_PCI]  = run && pci_go_s;
  assign grp_en[GRP_PCIF] = run;
  assign grp_en[GRP_REF]  = run;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pd_clk_group #(.HALF(grp_half(g))) i_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (grp_en[g]),
      .clk_o   (grp_clk[g]),
      .parked_o(grp_parked[g])
    );
  end

  assign all_parked = &grp_parked;

  assign cpu_clk_o  = grp_clk[GRP_CPU];
  assign pci_clk_o  = grp_clk[GRP_PCI];
  assign pcif_clk_o = grp_clk[GRP_PCIF];
  assign ref_clk_o  = grp_clk[GRP_REF];
  assign osc_en_o   = (state != ST_OFF);
  assign vco_en_o   = (state != ST_OFF);
  assign ready_o    = run;

  AST_OFF_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !(cpu_clk_o || pci_clk_o || pcif_clk_o || ref_clk_o)); // R3
  AST_OSC_FALL_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> $past(all_parked)); // R3
  AST_READY_OSC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (osc_en_o && vco_en_o)); // R4
  AST_NO_CLK_UNREADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !$past(ready_o)) |-> !$rose(grp_clk[GRP_CPU])); // R4
endmodule

// File: tb/test_pd_seq.sv
module test_pd_seq;
  localparam int STAB = 64;
  localparam int HALF_A [4] = '{2, 4, 4, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
  logic cpu_clk, pci_clk, pcif_clk, ref_clk, osc_en, vco_en, ready;

  always #10 clk = ~clk;

  pd_seq #(.CPU_HALF(2), .PCI_HALF(4), .REF_HALF(7), .STAB_CYCLES(STAB)) i_pd_seq (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n),
    .cpu_stop_ni(cpu_stop_n), .pci_stop_ni(pci_stop_n),
    .cpu_clk_o(cpu_clk), .pci_clk_o(pci_clk), .pcif_clk_o(pcif_clk), .ref_clk_o(ref_clk),
    .osc_en_o(osc_en), .vco_en_o(vco_en), .ready_o(ready)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard of {osc, vco, ready}
  logic [2:0] exp_q [$];
  logic [2:0] prev_vec = 3'b110;
  int rises [4] = '{0, 0, 0, 0};
  int hi [4] = '{0, 0, 0, 0};
  int lo [4] = '{0, 0, 0, 0};
  bit seen [4] = '{0, 0, 0, 0};
  logic [3:0] lv = 4'b0;
  bit bad_off = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [2:0] vec;
      logic [3:0] cv;
      vec = {osc_en, vco_en, ready};
      if (vec != prev_vec) begin
        if (exp_q.size() == 0) chk(0, "R3", "unexpected flag change", int'(vec), int'(prev_vec));
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk(vec == e, "R3", "flag sequence", int'(vec), int'(e));
        end
        prev_vec = vec;
      end
      cv = {ref_clk, pcif_clk, pci_clk, cpu_clk};
      if (!osc_en && cv != 4'b0) bad_off = 1;
      for (int g = 0; g < 4; g++) begin
        if (cv[g] && !lv[g]) begin
          rises[g]++;
          if (seen[g]) chk(lo[g] >= HALF_A[g], "R5", "low gap", lo[g], HALF_A[g]);
          hi[g] = 1; lo[g] = 0;
        end else if (cv[g]) hi[g]++;
        else if (lv[g]) begin
          chk(hi[g] == HALF_A[g], "R5", "high pulse", hi[g], HALF_A[g]);
          lo[g] = 1; seen[g] = 1;
        end else lo[g]++;
      end
      lv = cv;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pd(logic v);
    @(posedge clk); #2 pd_n = v;
  endtask

  task automatic wait_ready(string req);
    int n = 0;
    while (!ready && n < STAB + 40) begin @(negedge clk); n++; end
    chk(n >= STAB && n <= STAB + 5, req, "ready latency", n, STAB);
  endtask

  task automatic window(int n, output int d [4]);
    int s [4];
    for (int g = 0; g < 4; g++) s[g] = rises[g];
    cyc(n);
    for (int g = 0; g < 4; g++) d[g] = rises[g] - s[g];
  endtask

  initial begin
    int d [4];
    int n;
    cyc(3);
    @(posedge clk); #2 rst_n = 1'b1;
    exp_q.push_back(3'b111);
    cyc(2);
    chk(osc_en && vco_en, "R1", "osc/vco after reset", int'({osc_en, vco_en}), 3);
    chk(!ready, "R1", "ready after reset", int'(ready), 0);
    chk({ref_clk, pcif_clk, pci_clk, cpu_clk} == 4'b0, "R1", "clocks after reset",
        int'({ref_clk, pcif_clk, pci_clk, cpu_clk}), 0);
    n = 2;
    while (!ready && n < STAB + 40) begin @(negedge clk); n++; end
    chk(n >= STAB && n <= STAB + 5, "R4", "reset-to-ready", n, STAB);
    for (int g = 0; g < 4; g++) chk(rises[g] == 0 || seen[g] == 0, "R4", "no toggle before ready", rises[g], 0);
    cyc(20);

    window(84, d);
    chk(d[0] == 21, "R6", "cpu rises in 84", d[0], 21);
    chk(d[1] >= 10 && d[1] <= 11, "R6", "pci rises in 84", d[1], 10);
    chk(d[2] >= 10 && d[2] <= 11, "R6", "pcif rises in 84", d[2], 10);
    chk(d[3] == 6, "R6", "ref rises in 84", d[3], 6);

    @(posedge clk); #2 cpu_stop_n = 1'b0;
    cyc(12);
    window(40, d);
    chk(d[0] == 0, "R7", "cpu stopped", d[0], 0);
    chk(d[1] == 5, "R7", "pci runs during cpu stop", d[1], 5);
    chk(!cpu_clk, "R7", "cpu parked low", int'(cpu_clk), 0);
    @(posedge clk); #2 cpu_stop_n = 1'b1;
    cyc(12);
    window(40, d);
    chk(d[0] == 10, "R7", "cpu resumes", d[0], 10);

    @(posedge clk); #2 pci_stop_n = 1'b0;
    cyc(12);
    window(40, d);
    chk(d[1] == 0, "R8", "pci stopped", d[1], 0);
    chk(d[2] == 5, "R8", "pcif runs", d[2], 5);
    chk(d[0] == 10, "R8", "cpu runs", d[0], 10);
    @(posedge clk); #2 pci_stop_n = 1'b1;
    cyc(20);

    exp_q.push_back(3'b110);
    exp_q.push_back(3'b000);
    drive_pd(1'b0);
    cyc(8);
    window(30, d);
    chk(d[0] == 0 && !cpu_clk, "R2", "cpu parked within 3 periods", d[0], 0);
    n = 38;
    while (osc_en && n < 80) begin @(negedge clk); n++; end
    chk(!osc_en && !vco_en, "R3", "osc/vco off", int'({osc_en, vco_en}), 0);
    chk({ref_clk, pcif_clk, pci_clk, cpu_clk} == 4'b0, "R3", "clocks low when off",
        int'({ref_clk, pcif_clk, pci_clk, cpu_clk}), 0);

    @(posedge clk); #2 cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
    cyc(30);
    @(posedge clk); #2 cpu_stop_n = 1'b1;
    window(30, d);
    chk(d[0] + d[1] + d[2] + d[3] == 0, "R9", "no toggles with stops while off", d[0] + d[1] + d[2] + d[3], 0);
    chk(!osc_en, "R9", "osc stays off", int'(osc_en), 0);
    @(posedge clk); #2 pci_stop_n = 1'b1;

    exp_q.push_back(3'b110);
    drive_pd(1'b1);
    cyc(6);
    @(posedge clk); #2 cpu_stop_n = 1'b0;
    window(14, d);
    @(posedge clk); #2 cpu_stop_n = 1'b1;
    chk(d[0] + d[1] + d[2] + d[3] == 0, "R9", "no toggles with stop during wait", d[0] + d[1] + d[2] + d[3], 0);
    chk(osc_en && !ready, "R9", "still waiting", int'({osc_en, ready}), 2);
    exp_q.push_back(3'b000);
    drive_pd(1'b0);
    window(STAB + 30, d);
    chk(!ready && !osc_en, "R10", "abort stays off", int'({osc_en, ready}), 0);
    chk(d[0] + d[1] + d[2] + d[3] == 0, "R10", "no release after abort", d[0] + d[1] + d[2] + d[3], 0);

    exp_q.push_back(3'b110);
    exp_q.push_back(3'b111);
    drive_pd(1'b1);
    wait_ready("R4");
    cyc(10);
    window(56, d);
    chk(d[0] == 14, "R6", "cpu rises after wake", d[0], 14);
    chk(d[3] == 4, "R6", "ref rises after wake", d[3], 4);

    cyc(4);
    chk(exp_q.size() == 0, "R3", "pending flag transitions", exp_q.size(), 0);
    chk(!bad_off, "R3", "clock high while osc off", int'(bad_off), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule